// File: doc/BRIEF.md
# Parallel Streaming FFT Core

This block computes an N-point complex discrete Fourier transform on a frame that arrives whole in one clock cycle: all N time samples are presented side by side, and all N frequency bins leave side by side. One frame can be accepted every cycle, so the block sustains full throughput for wideband front ends where the sample rate is already divided into N parallel lanes.

The transform is a network of log2(N) ranks of radix-2 butterflies. Each butterfly forms a+W·b and a−W·b with a constant twiddle W. The twiddle multiply is replaced by wiring when W is 1 or −j. Inputs are taken in natural time order and bins leave in bit-reversed index order. A pipeline depth chosen at elaboration, from zero up to log2(N), sets how many rank outputs are registered. The input is never registered. The valid and sync flags travel through matching reset-cleared registers, so they stay aligned with the data.

Top module: `pfft_core`

## Requirements
- R1: While the reset is asserted, and until a valid input frame has crossed the pipeline, out_valid and out_sync are low.
- R2: out_valid equals in_valid delayed by exactly PIPE_DEPTH clock cycles. With PIPE_DEPTH of 0 it follows in_valid within the same cycle.
- R3: out_sync equals in_sync delayed by exactly PIPE_DEPTH cycles, including sync pulses given while in_valid is low.
- R4: Output lane m carries DFT bin X[k], X[k] = sum over n of x[n]·exp(−j2πnk/N), where k is m with its log2(N) index bits reversed. Each real and imaginary part is within log2(N)+2 LSB of the exact value. Lane i of every packed bus occupies bits [i·width +: width] in two's complement, with input lane i holding sample x[i].
- R5: Frames given on consecutive valid cycles each produce their own spectrum on consecutive output cycles, with no stall and no gap.
- R6: Output width is IN_W+log2(N)+1. A full-scale input, including every sample at −2^(IN_W−1) on both parts, yields bin 0 = N times that value and all other bins at zero, with no wrap-around anywhere in the network.
- R7: in_sync must be high on every cycle where in_valid is high, because each cycle carries a complete frame. The outputs keep this relation.
- R8: With PIPE_DEPTH of at least 1, the output bins hold the last valid spectrum on cycles where out_valid is low, even though the input data keeps changing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input frame valid |
| in_sync | input | 1 | Frame boundary flag; high whenever in_valid is high |
| in_re | input | N_PTS*IN_W | Real parts of samples x[0..N−1], lane i at [i*IN_W +: IN_W] |
| in_im | input | N_PTS*IN_W | Imaginary parts of samples, same packing |
| out_valid | output | 1 | Output spectrum valid |
| out_sync | output | 1 | Delayed sync flag |
| out_re | output | N_PTS*OUT_W | Real parts of bins in bit-reversed order, lane m at [m*OUT_W +: OUT_W] |
| out_im | output | N_PTS*OUT_W | Imaginary parts of bins, same packing |

## Verification
Every result of a frame given in cycle c is due in cycle c+PIPE_DEPTH: the flags, the bins, and the held values during bubbles. For depth 0 that is the same cycle, after the combinational network settles. The bench drives each cycle on the falling edge and records the expected flags and the reference spectrum in a 64-entry history indexed by cycle number. A short delay later, still before the next rising edge, it compares each instance against the entry PIPE_DEPTH cycles back. Three instances with depths 3, 0 and 1 see the same stimulus, so both full and partial register placement are measured against their own latency.

// File: rtl/pfft_pkg.sv
package pfft_pkg;

  // reverse the low 'bits' bits of v
  function automatic int pf_bitrev(input int v, input int bits);
    int r;
    r = 0;
    for (int i = 0; i < bits; i++) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

  // 1 when a register follows rank r; spread evenly, later ranks first
  function automatic bit pf_reg_after(input int r, input int ranks, input int depth);
    return (((r + 1) * depth) / ranks) > ((r * depth) / ranks);
  endfunction

  function automatic real pf_cos(input real x);
    real term, acc;
    term = 1.0;
    acc  = 1.0;
    for (int i = 1; i < 24; i++) begin
      term = -term * x * x / ((2.0 * i - 1.0) * (2.0 * i));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic real pf_sin(input real x);
    real term, acc;
    term = x;
    acc  = x;
    for (int i = 1; i < 24; i++) begin
      term = -term * x * x / ((2.0 * i) * (2.0 * i + 1.0));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // fixed-point twiddle exp(-j*2*pi*e/n): real part or imaginary part
  function automatic int pf_twid(input int e, input int n, input int frac, input bit want_im);
    real theta, v, scale;
    theta = 6.283185307179586 * e / n;
    scale = 1.0;
    for (int i = 0; i < frac; i++) scale = scale * 2.0;
    v = want_im ? -pf_sin(theta) : pf_cos(theta);
    v = v * scale;
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

endpackage

// File: rtl/pfft_bfly.sv
module pfft_bfly #(
  parameter int N_PTS   = 8,
  parameter int DW      = 16,
  parameter int TW_FRAC = 14,
  parameter int TW_EXP  = 0
) (
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  output logic signed [DW-1:0] top_re,
  output logic signed [DW-1:0] top_im,
  output logic signed [DW-1:0] bot_re,
  output logic signed [DW-1:0] bot_im
);
  localparam int TW_W = TW_FRAC + 2;

  logic signed [DW-1:0] p_re, p_im;

  generate
    if (TW_EXP == 0) begin : g_unity
      always_comb begin
        p_re = b_re;
        p_im = b_im;
      end
    end else if (TW_EXP == N_PTS / 4) begin : g_minus_j
      // (br + j bi)(-j) = bi - j br
      always_comb begin
        p_re = b_im;
        p_im = -b_re;
      end
    end else begin : g_mult
      localparam int AW = DW + TW_W + 1;
      localparam logic signed [TW_W-1:0] W_RE = TW_W'(pfft_pkg::pf_twid(TW_EXP, N_PTS, TW_FRAC, 1'b0));
      localparam logic signed [TW_W-1:0] W_IM = TW_W'(pfft_pkg::pf_twid(TW_EXP, N_PTS, TW_FRAC, 1'b1));
      localparam logic signed [AW-1:0]   RND  = AW'(1) <<< (TW_FRAC - 1);

      logic signed [AW-1:0] bre_x, bim_x, wre_x, wim_x, acc_re, acc_im;

      always_comb begin
        bre_x  = AW'(b_re);
        bim_x  = AW'(b_im);
        wre_x  = AW'(W_RE);
        wim_x  = AW'(W_IM);
        acc_re = bre_x * wre_x - bim_x * wim_x + RND;
        acc_im = bre_x * wim_x + bim_x * wre_x + RND;
        p_re   = acc_re[TW_FRAC +: DW];
        p_im   = acc_im[TW_FRAC +: DW];
      end

      // scaled product must fit the data width
      always_comb begin
        p_no_overflow_r6: assert (((acc_re >>> TW_FRAC) == AW'(p_re)) &&
                                  ((acc_im >>> TW_FRAC) == AW'(p_im)))
          else $error("twiddle product exceeds data width");
      end
    end
  endgenerate

  always_comb begin
    top_re = a_re + p_re;
    top_im = a_im + p_im;
    bot_re = a_re - p_re;
    bot_im = a_im - p_im;
  end

  // the two outputs must always sum to twice the upper input (no wrap)
  logic signed [DW:0] pair_re, pair_im;
  always_comb begin
    pair_re = (DW+1)'(top_re) + (DW+1)'(bot_re);
    pair_im = (DW+1)'(top_im) + (DW+1)'(bot_im);
    p_bfly_pair_r4: assert ((pair_re == {a_re, 1'b0}) && (pair_im == {a_im, 1'b0}))
      else $error("butterfly outputs inconsistent");
  end

endmodule

// File: rtl/pfft_rank.sv
module pfft_rank #(
  parameter int N_PTS   = 8,
  parameter int DW      = 16,
  parameter int TW_FRAC = 14,
  parameter int RANK    = 0
) (
  input  logic [N_PTS*DW-1:0] x_re,
  input  logic [N_PTS*DW-1:0] x_im,
  output wire  [N_PTS*DW-1:0] y_re,
  output wire  [N_PTS*DW-1:0] y_im
);
  localparam int SPAN = N_PTS >> (RANK + 1);

  generate
    for (genvar q = 0; q < N_PTS / 2; q++) begin : g_pair
      localparam int BLK = q / SPAN;
      localparam int OFS = q % SPAN;
      localparam int I0  = BLK * 2 * SPAN + OFS;
      localparam int I1  = I0 + SPAN;
      localparam int EXP = pfft_pkg::pf_bitrev(BLK, RANK) * SPAN;

      pfft_bfly #(
        .N_PTS  (N_PTS),
        .DW     (DW),
        .TW_FRAC(TW_FRAC),
        .TW_EXP (EXP)
      ) u_bfly (
        .a_re  (x_re[I0*DW +: DW]),
        .a_im  (x_im[I0*DW +: DW]),
        .b_re  (x_re[I1*DW +: DW]),
        .b_im  (x_im[I1*DW +: DW]),
        .top_re(y_re[I0*DW +: DW]),
        .top_im(y_im[I0*DW +: DW]),
        .bot_re(y_re[I1*DW +: DW]),
        .bot_im(y_im[I1*DW +: DW])
      );
    end
  endgenerate

endmodule

// File: rtl/pfft_stage_reg.sv
module pfft_stage_reg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_in,
  input  logic         sync_in,
  input  logic [W-1:0] re_in,
  input  logic [W-1:0] im_in,
  output logic         vld_out,
  output logic         sync_out,
  output logic [W-1:0] re_out,
  output logic [W-1:0] im_out
);
  logic [W-1:0] re_d, im_d, re_q, im_q;
  logic         vld_q, sync_q;

  // next state: data advances only with a valid frame
  always_comb begin
    re_d = vld_in ? re_in : re_q;
    im_d = vld_in ? im_in : im_q;
  end

  always_ff @(posedge clk) begin
    re_q <= re_d;
    im_q <= im_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      vld_q  <= vld_in;
      sync_q <= sync_in;
    end
  end

  assign vld_out  = vld_q;
  assign sync_out = sync_q;
  assign re_out   = re_q;
  assign im_out   = im_q;

  p_stage_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_in |=> ($stable(re_out) && $stable(im_out)))
    else $error("stage data moved without a valid frame");

  p_tag_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in |=> vld_out)
    else $error("valid lost across stage");

endmodule

// File: rtl/pfft_core.sv
module pfft_core #(
  parameter int N_PTS      = 8,
  parameter int IN_W       = 12,
  parameter int TW_FRAC    = 14,
  parameter int PIPE_DEPTH = 3,
  localparam int LOG2N     = $clog2(N_PTS),
  localparam int OUT_W     = IN_W + LOG2N + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sync,
  input  logic [N_PTS*IN_W-1:0]    in_re,
  input  logic [N_PTS*IN_W-1:0]    in_im,
  output logic                     out_valid,
  output logic                     out_sync,
  output logic [N_PTS*OUT_W-1:0]   out_re,
  output logic [N_PTS*OUT_W-1:0]   out_im
);
  localparam int BUS_W = N_PTS * OUT_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_d, rsync_q;
  logic       rst_sync_n;

  always_comb rsync_d = {rsync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= rsync_d;
  end

  assign rst_sync_n = rsync_q[1];

  // per-boundary data and flags; index 0 is the unregistered input
  wire [BUS_W-1:0] st_re [LOG2N+1];
  wire [BUS_W-1:0] st_im [LOG2N+1];
  wire [BUS_W-1:0] rk_re [LOG2N];
  wire [BUS_W-1:0] rk_im [LOG2N];
  wire             st_v  [LOG2N+1];
  wire             st_s  [LOG2N+1];

  generate
    for (genvar k = 0; k < N_PTS; k++) begin : g_ext
      assign st_re[0][k*OUT_W +: OUT_W] = OUT_W'($signed(in_re[k*IN_W +: IN_W]));
      assign st_im[0][k*OUT_W +: OUT_W] = OUT_W'($signed(in_im[k*IN_W +: IN_W]));
    end
  endgenerate

  assign st_v[0] = in_valid;
  assign st_s[0] = in_sync;

  generate
    for (genvar r = 0; r < LOG2N; r++) begin : g_rank
      pfft_rank #(
        .N_PTS  (N_PTS),
        .DW     (OUT_W),
        .TW_FRAC(TW_FRAC),
        .RANK   (r)
      ) u_rank (
        .x_re(st_re[r]),
        .x_im(st_im[r]),
        .y_re(rk_re[r]),
        .y_im(rk_im[r])
      );

      if (pfft_pkg::pf_reg_after(r, LOG2N, PIPE_DEPTH)) begin : g_reg
        pfft_stage_reg #(.W(BUS_W)) u_stage (
          .clk     (clk),
          .rst_n   (rst_sync_n),
          .vld_in  (st_v[r]),
          .sync_in (st_s[r]),
          .re_in   (rk_re[r]),
          .im_in   (rk_im[r]),
          .vld_out (st_v[r+1]),
          .sync_out(st_s[r+1]),
          .re_out  (st_re[r+1]),
          .im_out  (st_im[r+1])
        );
      end else begin : g_wire
        assign st_re[r+1] = rk_re[r];
        assign st_im[r+1] = rk_im[r];
        assign st_v[r+1]  = st_v[r];
        assign st_s[r+1]  = st_s[r];
      end
    end
  endgenerate

  assign out_valid = st_v[LOG2N];
  assign out_sync  = st_s[LOG2N];
  assign out_re    = st_re[LOG2N];
  assign out_im    = st_im[LOG2N];

  p_sync_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |-> in_sync)
    else $error("input valid without sync");

  p_out_sync_with_valid_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> out_sync)
    else $error("output valid without sync");

  p_reset_quiet_r1: assert property (@(posedge clk)
    (!rst_sync_n && !in_valid) |-> !out_valid)
    else $error("output valid during reset");

endmodule

// File: tb/pfft_core_bench.sv
`timescale 1ns/1ps
module pfft_core_bench;
  localparam int N    = 8;
  localparam int IW   = 12;
  localparam int FR   = 14;
  localparam int L    = 3;
  localparam int OW   = IW + L + 1;
  localparam int TOL  = L + 2;
  localparam int NDUT = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, in_valid, in_sync;
  logic [N*IW-1:0] in_re, in_im;
  logic          ov [NDUT];
  logic          os [NDUT];
  logic [N*OW-1:0] ore [NDUT];
  logic [N*OW-1:0] oim [NDUT];

  pfft_core #(.N_PTS(N), .IN_W(IW), .TW_FRAC(FR), .PIPE_DEPTH(3)) u_pfft_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
    .in_re(in_re), .in_im(in_im), .out_valid(ov[0]), .out_sync(os[0]),
    .out_re(ore[0]), .out_im(oim[0]));

  pfft_core #(.N_PTS(N), .IN_W(IW), .TW_FRAC(FR), .PIPE_DEPTH(0)) u_pfft_core_d0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
    .in_re(in_re), .in_im(in_im), .out_valid(ov[1]), .out_sync(os[1]),
    .out_re(ore[1]), .out_im(oim[1]));

  pfft_core #(.N_PTS(N), .IN_W(IW), .TW_FRAC(FR), .PIPE_DEPTH(1)) u_pfft_core_d1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
    .in_re(in_re), .in_im(in_im), .out_valid(ov[2]), .out_sync(os[2]),
    .out_re(ore[2]), .out_im(oim[2]));

  int    errors, checks, cyc;
  bit    done;
  int    cur_re [N];
  int    cur_im [N];
  bit    ev [64];
  bit    es [64];
  real   er [64][N];
  real   ei [64][N];
  string etag [64];
  logic [N*OW-1:0] prev_re [NDUT];
  logic [N*OW-1:0] prev_im [NDUT];
  bit    seen [NDUT];

  function automatic int depth_of(input int d);
    return (d == 0) ? 3 : ((d == 1) ? 0 : 1);
  endfunction

  function automatic int rev_idx(input int v);
    int r;
    r = 0;
    for (int i = 0; i < L; i++) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

  task automatic report(input bit ok, input string line);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", line);
    end
  endtask

  // reference spectrum for the current frame, stored by output lane
  task automatic store_expected(input int idx);
    for (int m = 0; m < N; m++) begin
      int  k;
      real sr, si, a;
      k  = rev_idx(m);
      sr = 0.0;
      si = 0.0;
      for (int n = 0; n < N; n++) begin
        a  = 6.283185307179586 * n * k / N;
        sr = sr + cur_re[n] * $cos(a) + cur_im[n] * $sin(a);
        si = si + cur_im[n] * $cos(a) - cur_re[n] * $sin(a);
      end
      er[idx][m] = sr;
      ei[idx][m] = si;
    end
  endtask

  task automatic check_dut(input int d);
    int dd, idx;
    dd = depth_of(d);
    if (cyc < dd) return;
    idx = (cyc - dd) % 64;
    report(ov[d] == ev[idx], $sformatf("R2 dut%0d cycle %0d valid got %0b expected %0b",
                                       d, cyc, ov[d], ev[idx]));
    report(os[d] == es[idx], $sformatf("R3 dut%0d cycle %0d sync got %0b expected %0b",
                                       d, cyc, os[d], es[idx]));
    if (ov[d]) report(os[d], $sformatf("R7 dut%0d cycle %0d sync with valid got %0b expected 1",
                                       d, cyc, os[d]));
    if (ev[idx]) begin
      for (int m = 0; m < N; m++) begin
        int  gr, gi;
        real dr, di;
        gr = int'($signed(ore[d][m*OW +: OW]));
        gi = int'($signed(oim[d][m*OW +: OW]));
        dr = $itor(gr) - er[idx][m];
        di = $itor(gi) - ei[idx][m];
        if (dr < 0.0) dr = -dr;
        if (di < 0.0) di = -di;
        report((dr <= TOL) && (di <= TOL),
               $sformatf("%s dut%0d cycle %0d lane %0d got (%0d,%0d) expected (%0.2f,%0.2f)",
                         etag[idx], d, cyc, m, gr, gi, er[idx][m], ei[idx][m]));
      end
      seen[d] = 1'b1;
    end else if (seen[d] && dd > 0) begin
      report((ore[d] == prev_re[d]) && (oim[d] == prev_im[d]),
             $sformatf("R8 dut%0d cycle %0d hold got %h expected %h", d, cyc, ore[d], prev_re[d]));
    end
    prev_re[d] = ore[d];
    prev_im[d] = oim[d];
  endtask

  task automatic step(input bit v, input bit s, input string tag);
    int idx;
    @(negedge clk);
    for (int n = 0; n < N; n++) begin
      in_re[n*IW +: IW] = IW'(cur_re[n]);
      in_im[n*IW +: IW] = IW'(cur_im[n]);
    end
    in_valid = v;
    in_sync  = s;
    idx       = cyc % 64;
    ev[idx]   = v;
    es[idx]   = s;
    etag[idx] = tag;
    store_expected(idx);
    #1;
    for (int d = 0; d < NDUT; d++) check_dut(d);
    cyc++;
  endtask

  task automatic fill_random();
    for (int n = 0; n < N; n++) begin
      cur_re[n] = int'($urandom_range(0, (1 << IW) - 1)) - (1 << (IW - 1));
      cur_im[n] = int'($urandom_range(0, (1 << IW) - 1)) - (1 << (IW - 1));
    end
  endtask

  task automatic fill_const(input int vr, input int vi);
    for (int n = 0; n < N; n++) begin
      cur_re[n] = vr;
      cur_im[n] = vi;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R5 watchdog: got no completion, expected completion");
      finish_run();
    end
  end

  initial begin
    errors = 0; checks = 0; cyc = 0; done = 1'b0;
    void'($urandom(32'h1f2e3d4c));
    for (int d = 0; d < NDUT; d++) seen[d] = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_sync = 1'b0; in_re = '0; in_im = '0;
    fill_const(0, 0);

    // R1: quiet during reset
    repeat (4) begin
      @(negedge clk);
      #1;
      for (int d = 0; d < NDUT; d++)
        report(!ov[d] && !os[d], $sformatf("R1 dut%0d reset flags got %0b%0b expected 00",
                                           d, ov[d], os[d]));
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: still quiet before the first valid frame
    repeat (3) step(1'b0, 1'b0, "R1 idle");

    // directed frames, back to back
    fill_const(0, 0); cur_re[0] = 1000;
    step(1'b1, 1'b1, "R4 impulse at x0");
    fill_const(0, 0); cur_re[1] = 1000; cur_im[1] = 500;
    step(1'b1, 1'b1, "R4 impulse at x1");
    fill_const(2047, 0);
    step(1'b1, 1'b1, "R6 full-scale positive");
    fill_const(-2048, -2048);
    step(1'b1, 1'b1, "R6 full-scale negative");
    for (int n = 0; n < N; n++) begin
      cur_re[n] = (n % 2 == 0) ? 2047 : -2047;
      cur_im[n] = (n % 2 == 0) ? -2048 : 2047;
    end
    step(1'b1, 1'b1, "R4 alternating");
    repeat (4) begin
      fill_random();
      step(1'b1, 1'b1, "R5 back-to-back");
    end

    // R3: sync without valid, then bubbles with changing data (R8)
    fill_random();
    step(1'b0, 1'b1, "R3 sync while idle");
    fill_random();
    step(1'b0, 1'b0, "R8 bubble");
    fill_random();
    step(1'b0, 1'b0, "R8 bubble");

    // random traffic
    repeat (300) begin
      bit v, s;
      v = ($urandom % 5) != 0;
      s = v ? 1'b1 : (($urandom % 4) == 0);
      fill_random();
      step(v, s, "R4 random");
    end

    repeat (5) begin
      fill_random();
      step(1'b0, 1'b0, "R8 flush");
    end

    done = 1'b1;
    finish_run();
  end

endmodule